// File: doc/BRIEF.md
# Sequential Integer Divider with Divide-Error Trap

This block performs integer division over several clock cycles for a processor datapath that keeps its operands in an accumulator and a high word. It supports two operand sizes. In byte size, a 16-bit accumulator is divided by an 8-bit divisor. The quotient lands in the accumulator's low byte and the remainder in its high byte. In word size, the 32-bit value formed by the high word over the accumulator is divided by a 16-bit divisor. The quotient replaces the accumulator and the remainder replaces the high word. Each size can run as unsigned or as signed (two's complement).

A request enters on a valid/ready handshake. `in_ready` is high only while the unit is idle. A request is taken on any rising edge where both `in_valid` and `in_ready` are high. While the unit is busy, `in_ready` stays low, so the operands on the input pins are neither captured nor queued. The caller must hold its request until it is taken. Results leave with no back-pressure. A completed division raises `done` for one cycle and updates the held `acc_out`/`hi_out` registers. A failed division raises `trap` for one cycle instead and presents the divide-error vector. Dispatching that trap is left to the surrounding core.

Internally, a restoring shift-subtract engine works on magnitudes, one quotient bit per cycle. Signs are applied afterwards. A zero divisor, or a dividend whose upper half is already at least the divisor, is rejected before any iteration.

Top module: `seq_divider`

## Requirements
- R1: Unsigned byte size: quotient = in_acc / in_dvsr[7:0] and remainder = in_acc % in_dvsr[7:0]. On `done`, acc_out = {remainder[7:0], quotient[7:0]} (remainder in bits 15:8) and hi_out keeps its previous value.
- R2: Unsigned word size: quotient = {in_hi, in_acc} / in_dvsr and remainder = {in_hi, in_acc} % in_dvsr. On `done`, acc_out = quotient and hi_out = remainder.
- R3: Signed mode (in_signed = 1): the divisor is sign-extended from bit 7 in byte size and from bit 15 in word size, and in_dvsr[15:8] is ignored in byte size. The quotient is truncated toward zero, and the remainder carries the sign of the dividend.
- R4: An unsigned quotient above 0xFF (byte size) or above 0xFFFF (word size) raises `trap`. acc_out and hi_out keep their previous values.
- R5: A signed quotient outside -128..127 (byte size) or outside -32768..32767 (word size) raises `trap` with no register update.
- R6: A zero divisor (in_dvsr[7:0] in byte size, in_dvsr in word size) raises `trap` in the cycle right after acceptance, with no iteration.
- R7: A division that does not trap early raises `done`, or a late `trap`, exactly 9 rising edges (byte size) or 17 rising edges (word size) after the accepting edge. `done` lasts one cycle.
- R8: `done` and `trap` are never high together. While `trap` is high, trap_vec equals 0, the divide-error vector.
- R9: While a division is in progress, in_ready is low and in_valid has no effect. The running division's result is unchanged, and no extra completion follows.
- R10: After reset, in_ready = 1, done = 0, trap = 0, acc_out = 0 and hi_out = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit idle, request can be taken |
| in_word | input | 1 | 1 = word size, 0 = byte size |
| in_signed | input | 1 | 1 = two's complement operands |
| in_acc | input | 16 | Accumulator operand |
| in_hi | input | 16 | High-word operand (word size only) |
| in_dvsr | input | 16 | Divisor (low byte in byte size) |
| done | output | 1 | One-cycle pulse, results written |
| trap | output | 1 | One-cycle divide-error pulse |
| trap_vec | output | 8 | Vector number while trap is high |
| acc_out | output | 16 | Accumulator result register |
| hi_out | output | 16 | High-word result register |

## Verification
Two things can land on the same edge. The edge that completes one division, raising `done` or a late `trap`, reopens `in_ready`, and a new request may be taken on the next edge. The bench also drives a competing request while a division is running, then releases `in_valid` exactly when `done` appears. It judges the case by the running division's result matching the reference model, by `in_ready` reading low during the stall, and by no second completion appearing afterwards. Early and late traps are told apart by the number of edges between acceptance and the pulse.

// File: rtl/divu_pkg.sv
package divu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_prep.sv
// Operand conditioning: magnitudes, signs, zero and early-overflow detection.
module div_prep #(
  parameter int W = 16
) (
  input  logic         word_mode,
  input  logic         signed_mode,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] dvsr,
  output logic [W-1:0] r_init,
  output logic [W-1:0] q_init,
  output logic [W-1:0] den_mag,
  output logic         num_neg,
  output logic         den_neg,
  output logic         den_zero,
  output logic         early_ovf
);
  localparam int H = W / 2;

  logic         nb_neg, nw_neg, db_neg, dw_neg;
  logic [W-1:0]   nb_abs;
  logic [2*W-1:0] nw_abs;
  logic [H-1:0]   db_abs;
  logic [W-1:0]   dw_abs;

  always_comb begin
    nb_neg = signed_mode & acc[W-1];
    nb_abs = nb_neg ? (~acc + 1'b1) : acc;
    nw_neg = signed_mode & hi[W-1];
    nw_abs = nw_neg ? (~{hi, acc} + 1'b1) : {hi, acc};
    db_neg = signed_mode & dvsr[H-1];
    db_abs = db_neg ? (~dvsr[H-1:0] + 1'b1) : dvsr[H-1:0];
    dw_neg = signed_mode & dvsr[W-1];
    dw_abs = dw_neg ? (~dvsr + 1'b1) : dvsr;

    if (word_mode) begin
      r_init  = nw_abs[2*W-1:W];
      q_init  = nw_abs[W-1:0];
      den_mag = dw_abs;
      num_neg = nw_neg;
      den_neg = dw_neg;
    end else begin
      // Byte size: upper dividend half zero-extended, lower half left-aligned
      r_init  = {{H{1'b0}}, nb_abs[W-1:H]};
      q_init  = {nb_abs[H-1:0], {H{1'b0}}};
      den_mag = {{H{1'b0}}, db_abs};
      num_neg = nb_neg;
      den_neg = db_neg;
    end
    den_zero  = (den_mag == '0);
    early_ovf = (r_init >= den_mag);
  end
endmodule

// File: rtl/div_core.sv
// Restoring shift-subtract engine on magnitudes, one quotient bit per cycle.
module div_core #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] steps,
  input  logic [W-1:0]  r_init,
  input  logic [W-1:0]  q_init,
  input  logic [W-1:0]  d_init,
  output logic [W-1:0]  quo,
  output logic [W-1:0]  rem,
  output logic          last
);
  logic [W-1:0]  r_q, q_q, d_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    shifted, diff;
  logic          fits;

  always_comb begin
    shifted = {r_q, q_q[W-1]};
    diff    = shifted - {1'b0, d_q};
    fits    = ~diff[W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_q   <= '0;
      q_q   <= '0;
      d_q   <= '0;
      cnt_q <= '0;
    end else if (load) begin
      r_q   <= r_init;
      q_q   <= q_init;
      d_q   <= d_init;
      cnt_q <= steps;
    end else if (cnt_q != '0) begin
      r_q   <= fits ? diff[W-1:0] : shifted[W-1:0];
      q_q   <= {q_q[W-2:0], fits};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign quo  = q_q;
  assign rem  = r_q;
  assign last = (cnt_q == CW'(1));

  // R2: partial remainder stays below the divisor while iterating
  a_r2_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (r_q < d_q));
endmodule

// File: rtl/div_fix.sv
// Sign restoration and destination-range check.
module div_fix #(
  parameter int W = 16
) (
  input  logic         word_mode,
  input  logic         signed_mode,
  input  logic         num_neg,
  input  logic         den_neg,
  input  logic [W-1:0] quo_mag,
  input  logic [W-1:0] rem_mag,
  output logic [W-1:0] res_acc,
  output logic [W-1:0] res_hi,
  output logic         range_ovf
);
  localparam int H = W / 2;
  localparam logic [W-1:0] BPOS = W'((1 << (H - 1)) - 1);
  localparam logic [W-1:0] BNEG = W'(1 << (H - 1));
  localparam logic [W-1:0] WPOS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] WNEG = {1'b1, {(W-1){1'b0}}};

  logic         q_neg;
  logic [W-1:0] q_s, r_s, lim;

  always_comb begin
    q_neg = signed_mode & (num_neg ^ den_neg);
    q_s   = q_neg ? (~quo_mag + 1'b1) : quo_mag;
    r_s   = num_neg ? (~rem_mag + 1'b1) : rem_mag;
    if (word_mode) lim = q_neg ? WNEG : WPOS;
    else           lim = q_neg ? BNEG : BPOS;
    range_ovf = signed_mode & (quo_mag > lim);
    res_acc   = word_mode ? q_s : {r_s[H-1:0], q_s[H-1:0]};
    res_hi    = r_s;
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W       = 16,
  parameter int VEC_W   = 8,
  parameter int ERR_VEC = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_word,
  input  logic             in_signed,
  input  logic [W-1:0]     in_acc,
  input  logic [W-1:0]     in_hi,
  input  logic [W-1:0]     in_dvsr,
  output logic             done,
  output logic             trap,
  output logic [VEC_W-1:0] trap_vec,
  output logic [W-1:0]     acc_out,
  output logic [W-1:0]     hi_out
);
  import divu_pkg::*;
  localparam int H  = W / 2;
  localparam int CW = $clog2(W + 1);

  div_state_e   state_q;
  logic         word_q, signed_q, nneg_q, dneg_q;
  logic         done_q, trap_q;
  logic [W-1:0] acc_q, hi_q;

  logic [W-1:0] r_init, q_init, den_mag, quo, rem, fix_acc, fix_hi;
  logic         num_neg, den_neg, den_zero, early_ovf, core_last, range_ovf;
  logic         accept, load;

  div_prep #(.W(W)) u_prep (
    .word_mode(in_word), .signed_mode(in_signed),
    .acc(in_acc), .hi(in_hi), .dvsr(in_dvsr),
    .r_init(r_init), .q_init(q_init), .den_mag(den_mag),
    .num_neg(num_neg), .den_neg(den_neg),
    .den_zero(den_zero), .early_ovf(early_ovf)
  );

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid & in_ready;
  assign load     = accept & ~den_zero & ~early_ovf;

  div_core #(.W(W), .CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .load(load),
    .steps(in_word ? CW'(W) : CW'(H)),
    .r_init(r_init), .q_init(q_init), .d_init(den_mag),
    .quo(quo), .rem(rem), .last(core_last)
  );

  div_fix #(.W(W)) u_fix (
    .word_mode(word_q), .signed_mode(signed_q),
    .num_neg(nneg_q), .den_neg(dneg_q),
    .quo_mag(quo), .rem_mag(rem),
    .res_acc(fix_acc), .res_hi(fix_hi), .range_ovf(range_ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      word_q   <= 1'b0;
      signed_q <= 1'b0;
      nneg_q   <= 1'b0;
      dneg_q   <= 1'b0;
      done_q   <= 1'b0;
      trap_q   <= 1'b0;
      acc_q    <= '0;
      hi_q     <= '0;
    end else begin
      done_q <= 1'b0;
      trap_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          word_q   <= in_word;
          signed_q <= in_signed;
          nneg_q   <= num_neg;
          dneg_q   <= den_neg;
          if (den_zero || early_ovf) trap_q  <= 1'b1;
          else                       state_q <= ST_RUN;
        end
        ST_RUN: if (core_last) state_q <= ST_FIX;
        ST_FIX: begin
          state_q <= ST_IDLE;
          if (range_ovf) trap_q <= 1'b1;
          else begin
            done_q <= 1'b1;
            acc_q  <= fix_acc;
            if (word_q) hi_q <= fix_hi;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done     = done_q;
  assign trap     = trap_q;
  assign trap_vec = trap_q ? VEC_W'(ERR_VEC) : '0;
  assign acc_out  = acc_q;
  assign hi_out   = hi_q;

  // R8: completion and error never coincide
  a_r8_done_trap_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && trap));
  // R7: done is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4: a trap leaves the result registers untouched
  a_r4_hold_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> ($stable(acc_out) && $stable(hi_out)));
  // R1: byte-size completion does not touch the high word
  a_r1_byte_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !word_q) |-> $stable(hi_out));
  // R6: zero divisor traps on the very next cycle
  a_r6_zero_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && den_zero) |=> trap);
  // R9: no request is taken while busy
  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |=> !in_ready);
endmodule

// File: tb/seq_divider_tb.sv
module seq_divider_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_word = 1'b0;
  logic        in_signed = 1'b0;
  logic [15:0] in_acc = '0, in_hi = '0, in_dvsr = '0;
  logic        in_ready, done, trap;
  logic [7:0]  trap_vec;
  logic [15:0] acc_out, hi_out;

  int total = 0;
  int fails = 0;
  logic [15:0] m_acc = '0, m_hi = '0;

  always #2.5 clk = ~clk;

  seq_divider u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_signed(in_signed), .in_acc(in_acc), .in_hi(in_hi),
    .in_dvsr(in_dvsr), .done(done), .trap(trap), .trap_vec(trap_vec),
    .acc_out(acc_out), .hi_out(hi_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference: returns trap flag and new acc/hi
  task automatic model(input bit w, input bit s, input logic [15:0] a, input logic [15:0] h,
                       input logic [15:0] dv, output bit tr, output logic [15:0] na,
                       output logic [15:0] nh);
    longint n, d, q, r;
    if (w) n = s ? longint'($signed({h, a})) : longint'({h, a});
    else   n = s ? longint'($signed(a)) : longint'(a);
    if (w) d = s ? longint'($signed(dv)) : longint'(dv);
    else   d = s ? longint'($signed(dv[7:0])) : longint'(dv[7:0]);
    na = m_acc; nh = m_hi; tr = 1'b0;
    if (d == 0) begin tr = 1'b1; return; end
    q = n / d;
    r = n % d;
    if (!s) tr = w ? (q > 65535) : (q > 255);
    else    tr = w ? (q > 32767 || q < -32768) : (q > 127 || q < -128);
    if (tr) return;
    if (w) begin na = q[15:0]; nh = r[15:0]; end
    else     na = {r[7:0], q[7:0]};
  endtask

  task automatic run_op(input bit w, input bit s, input logic [15:0] a, input logic [15:0] h,
                        input logic [15:0] dv, input bit poke);
    bit tr; logic [15:0] na, nh; int k; int lat;
    model(w, s, a, h, dv, tr, na, nh);
    lat = w ? 17 : 9;
    @(negedge clk);
    chk(in_ready, "R9 ready when idle", in_ready, 1);
    in_valid = 1'b1; in_word = w; in_signed = s; in_acc = a; in_hi = h; in_dvsr = dv;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    k = 0;
    while (!(done || trap) && k < 40) begin
      if (poke && k == 2) begin
        chk(!in_ready, "R9 ready low while busy", in_ready, 0);
        in_valid = 1'b1; in_word = ~w; in_signed = ~s; in_acc = ~a; in_hi = ~h;
        in_dvsr = 16'h0001;
      end
      @(posedge clk);
      @(negedge clk);
      k++;
    end
    in_valid = 1'b0;
    chk(!(done && trap), "R8 done/trap exclusive", {done, trap}, 0);
    if (tr) begin
      chk(trap, "R4 R5 R6 trap raised", trap, 1);
      chk(trap_vec == 8'd0, "R8 trap vector", trap_vec, 0);
      chk(k == 0 || k == lat, "R7 trap timing", k, lat);
      if ((w ? dv : {8'h00, dv[7:0]}) == 16'h0)
        chk(k == 0, "R6 zero divisor immediate", k, 0);
    end else begin
      chk(done, "R7 done raised", done, 1);
      chk(k == lat, "R7 latency", k, lat);
    end
    chk(acc_out == na, w ? "R2 R3 acc result" : "R1 R3 acc result", acc_out, na);
    chk(hi_out == nh, w ? "R2 R3 hi result" : "R1 R4 hi result", hi_out, nh);
    m_acc = na; m_hi = nh;
    @(posedge clk);
    @(negedge clk);
    chk(!done && !trap, "R7 single pulse", {done, trap}, 0);
    if (poke) begin
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (done || trap) chk(0, "R9 no extra completion", {done, trap}, 0);
      end
      chk(acc_out == na && hi_out == nh, "R9 busy request ignored", acc_out, na);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 reset ready", in_ready, 1);
    chk(!done && !trap, "R10 reset pulses", {done, trap}, 0);
    chk(acc_out == 0 && hi_out == 0, "R10 reset regs", {acc_out, hi_out}, 0);

    // directed corners
    run_op(0, 0, 16'h1234, 16'h0000, 16'h0056, 0);            // R1
    run_op(1, 0, 16'h2345, 16'h0001, 16'h1234, 0);            // R2
    run_op(0, 0, 16'h1234, 16'h0000, 16'h0010, 0);            // R4 byte overflow
    run_op(1, 0, 16'h0000, 16'h1234, 16'h1234, 0);            // R4 word overflow
    run_op(0, 0, 16'h00FF, 16'h0000, 16'hFF00, 0);            // R6 zero low byte
    run_op(1, 1, 16'h7777, 16'h0000, 16'h0000, 0);            // R6 word zero
    run_op(0, 1, 16'hFFF9, 16'h0000, 16'h0002, 0);            // R3 -7/2
    run_op(0, 1, 16'h0007, 16'h0000, 16'hABFE, 0);            // R3 divisor sign-ext
    run_op(0, 1, 16'hFF00, 16'h0000, 16'h0002, 0);            // R5 -128 fits
    run_op(0, 1, 16'h0100, 16'h0000, 16'h0002, 0);            // R5 +128 traps late
    run_op(0, 1, 16'h4000, 16'h0000, 16'h0080, 0);            // R3 divide by -128
    run_op(1, 1, 16'h0000, 16'hFFFF, 16'h0002, 0);            // R5 -32768 fits
    run_op(1, 1, 16'h0000, 16'h0001, 16'h0002, 0);            // R5 +32768 traps
    run_op(1, 1, 16'h8001, 16'hFFFF, 16'hFFFD, 0);            // R3 neg/neg
    run_op(1, 0, 16'hBEEF, 16'h0012, 16'h00F3, 1);            // R9 request while busy
    run_op(0, 0, 16'h0FFF, 16'h0000, 16'h00FF, 1);            // R9 byte

    // constrained random
    for (int i = 0; i < 400; i++) begin
      bit w, s; logic [15:0] a, h, dv; int sel;
      w = $urandom_range(0, 1); s = $urandom_range(0, 1);
      a = 16'($urandom); h = 16'($urandom); dv = 16'($urandom);
      sel = $urandom_range(0, 9);
      if (sel < 4)       h = s ? {{12{h[15]}}, h[3:0]} : {12'h000, h[3:0]};
      else if (sel == 4) dv = 16'h0000;
      else if (sel == 5) dv = {8'($urandom), 8'h00};
      else if (sel == 6) a = s ? {{9{a[15]}}, a[6:0]} : {9'h000, a[6:0]};
      run_op(w, s, a, h, dv, 0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule